// File: doc/BRIEF.md
# Dual alarm match comparator

This block keeps two independent alarm settings for a calendar clock and reports when the running time reaches either of them. Each alarm stores six BCD fields (seconds, minutes, hours, date, month and weekday), and each stored field has its own compare-enable bit. Only the enabled fields of an alarm take part in its comparison. This lets one alarm fire once a day, once an hour, or once a year, depending on which fields are enabled.

Software loads alarm fields one byte at a time through a small write port. The time-keeping logic presents the current time on a 48-bit bus and pulses a one-second tick. On each tick edge, each alarm compares its enabled fields with the time bus. An alarm whose enabled fields all agree sets its sticky flag. A flag stays set until its clear input is pulsed. If a clear and a new match occur in the same cycle, the match wins.

Top module: `dual_alarm_matcher`

## Requirements
- R1: After reset, both flags read 0 and every field of both alarms is disabled with value 0.
- R2: When `tick_i` is high at a clock edge and every enabled field of alarm n equals the time bus, `flag_o[n]` reads 1 from that edge on.
- R3: A field whose enable bit is 0 takes no part in the comparison: a mismatch in that field does not stop the match.
- R4: An alarm with no field enabled never sets its flag.
- R5: Without a tick, a matching time leaves the flag unchanged, however long the match lasts.
- R6: A set flag holds until `clr_i[n]` is high at an edge. The flag then reads 0 from that edge on, provided no new match occurs in that cycle.
- R7: If the clear and a tick-qualified match of the same alarm occur at the same edge, the flag ends up set.
- R8: The two alarms are independent. A write with `wr_sel_i` = n changes only alarm n, and each flag follows only its own alarm.
- R9: Write encoding. `wr_field_i` selects the field: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 weekday. `wr_data_i[7]` is the enable bit and `wr_data_i[6:0]` is the BCD value. A write with a field index of 6 or 7 changes nothing.
- R10: The time bus carries seconds in bits [7:0], minutes in [15:8], hours in [23:16], date in [31:24], month in [39:32] and weekday in [47:40]. Bit 7 of each byte is not compared, so the 12/24-hour mode bit in the hour byte is ignored.
- R11: A single enabled field that differs from the time bus prevents the flag from being set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Alarm field write strobe |
| wr_sel_i | input | 1 | Alarm index for the write |
| wr_field_i | input | 3 | Field index for the write |
| wr_data_i | input | 8 | Enable bit [7] and BCD value [6:0] |
| time_i | input | 48 | Current time, six BCD bytes |
| tick_i | input | 1 | One-second compare strobe |
| clr_i | input | 2 | Per-alarm flag clear |
| flag_o | output | 2 | Per-alarm sticky match flags |

## Verification
Every result in this block is due one clock edge after its stimulus. A field write is visible to the comparison on the cycle after its strobe. A flag changes at the edge that samples the tick or the clear, and `flag_o` shows the new value right after that edge. The bench applies all inputs on the falling edge, lets exactly one rising edge pass, and then reads `flag_o` on the next falling edge. The check for R5 holds a matching time for several untick'd cycles before it samples.

// File: rtl/dam_pkg.sv
package dam_pkg;
  localparam int unsigned NUM_ALARMS = 2;
  localparam int unsigned NUM_FIELDS = 6;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned VAL_W      = BYTE_W - 1;
  localparam int unsigned IDX_W      = 3;

  typedef enum logic [IDX_W-1:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DATE  = 3'd3,
    FLD_MONTH = 3'd4,
    FLD_WDAY  = 3'd5
  } field_e;
endpackage

// File: rtl/alarm_bank.sv
module alarm_bank #(
  parameter int unsigned NF = 6,
  parameter int unsigned FW = 8,
  parameter int unsigned IW = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IW-1:0]    wr_field_i,
  input  logic [FW-1:0]    wr_data_i,
  output logic [NF*FW-1:0] regs_o
);
  localparam int unsigned TOT_W = NF * FW;

  logic [TOT_W-1:0] regs_q, regs_d;
  logic             fld_ok;

  // Indices at or above the field count select no field.
  assign fld_ok = (32'(wr_field_i) < NF);

  always_comb begin
    regs_d = regs_q;
    if (wr_en_i && fld_ok) begin
      regs_d[wr_field_i*FW +: FW] = wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else if (wr_en_i) begin
      regs_q <= regs_d;
    end
  end

  assign regs_o = regs_q;

  // R9: an out-of-range field index leaves every stored byte unchanged
  p_bad_index_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !fld_ok) |=> $stable(regs_o));

  // R9: no strobe, no change
  p_idle_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(regs_o));
endmodule

// File: rtl/alarm_compare.sv
module alarm_compare #(
  parameter int unsigned NF = 6,
  parameter int unsigned FW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NF*FW-1:0] regs_i,
  input  logic [NF*FW-1:0] now_i,
  output logic             match_o
);
  localparam int unsigned VW = FW - 1;

  logic [NF-1:0] en_vec;
  logic [NF-1:0] hit_vec;
  logic [NF-1:0] unused_mode_bits;

  for (genvar f = 0; f < NF; f++) begin : g_field
    logic [VW-1:0] alm_val, cur_val;
    assign alm_val             = regs_i[f*FW +: VW];
    assign cur_val             = now_i[f*FW +: VW];
    assign en_vec[f]           = regs_i[f*FW + VW];
    assign unused_mode_bits[f] = now_i[f*FW + VW];
    // A disabled field always counts as agreeing.
    assign hit_vec[f]          = !en_vec[f] || (alm_val == cur_val);
  end

  assign match_o = (|en_vec) && (&hit_vec);

  // R4: no enabled field means no match
  p_no_enable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_vec == '0) |-> !match_o);
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic match_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d, set_now;

  assign set_now = tick_i && match_i;

  // Set dominates clear.
  always_comb begin
    flag_d = flag_q;
    if (clr_i)   flag_d = 1'b0;
    if (set_now) flag_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  // R2, R7: a ticked match always leaves the flag set
  p_set_on_match_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && match_i) |=> flag_o);

  // R5: without a ticked match a clear flag stays clear
  p_no_spurious_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && !(tick_i && match_i)) |=> !flag_o);

  // R6: sticky while no clear
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);

  // R6: clear without a match empties the flag
  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(tick_i && match_i)) |=> !flag_o);
endmodule

// File: rtl/dual_alarm_matcher.sv
module dual_alarm_matcher
  import dam_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic                         wr_sel_i,
  input  logic [IDX_W-1:0]             wr_field_i,
  input  logic [BYTE_W-1:0]            wr_data_i,
  input  logic [NUM_FIELDS*BYTE_W-1:0] time_i,
  input  logic                         tick_i,
  input  logic [NUM_ALARMS-1:0]        clr_i,
  output logic [NUM_ALARMS-1:0]        flag_o
);
  localparam int unsigned TOT_W = NUM_FIELDS * BYTE_W;

  logic [NUM_ALARMS-1:0] match_vec;
  logic [TOT_W-1:0]      regs_arr [NUM_ALARMS];

  for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alarm
    logic bank_wr;
    assign bank_wr = wr_en_i && (32'(wr_sel_i) == a);

    alarm_bank #(.NF(NUM_FIELDS), .FW(BYTE_W), .IW(IDX_W)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (bank_wr),
      .wr_field_i (wr_field_i),
      .wr_data_i  (wr_data_i),
      .regs_o     (regs_arr[a])
    );

    alarm_compare #(.NF(NUM_FIELDS), .FW(BYTE_W)) u_cmp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .regs_i  (regs_arr[a]),
      .now_i   (time_i),
      .match_o (match_vec[a])
    );

    alarm_flag u_flag (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .match_i (match_vec[a]),
      .clr_i   (clr_i[a]),
      .flag_o  (flag_o[a])
    );

    // R8: a write aimed at the other alarm leaves this one untouched
    p_isolated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && (32'(wr_sel_i) != a)) |=> $stable(regs_arr[a]));
  end
endmodule

// File: tb/sim_dual_alarm_matcher.sv
module sim_dual_alarm_matcher;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic        wr_sel;
  logic [2:0]  wr_field;
  logic [7:0]  wr_data;
  logic [47:0] now;
  logic        tick;
  logic [1:0]  clr;
  logic [1:0]  flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_alarm_matcher u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_field_i(wr_field), .wr_data_i(wr_data), .time_i(now),
    .tick_i(tick), .clr_i(clr), .flag_o(flag)
  );

  task automatic check(input logic [1:0] act, input logic [1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: flags actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [2:0] fld, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_field = fld; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                          input logic [7:0] d, input logic [7:0] mo, input logic [7:0] w);
    @(negedge clk);
    now = {w, mo, d, h, m, s};
  endtask

  // one edge with tick and the given clear, flags sampled after it
  task automatic step(input logic t, input logic [1:0] c);
    @(negedge clk);
    tick = t; clr = c;
    @(negedge clk);
    tick = 1'b0; clr = 2'b00;
  endtask

  task automatic t_reset;
    check(flag, 2'b00, "R1 reset flags");
    set_time(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    step(1'b1, 2'b00);
    check(flag, 2'b00, "R1 R4 all fields disabled after reset");
  endtask

  task automatic t_basic;
    wr(1'b0, 3'd0, 8'hB0);   // sec 30 enabled
    wr(1'b0, 3'd1, 8'h95);   // min 15 enabled
    set_time(8'h30, 8'h15, 8'h12, 8'h04, 8'h07, 8'h02);
    repeat (4) @(negedge clk);
    check(flag, 2'b00, "R5 match without tick");
    step(1'b1, 2'b00);
    check(flag, 2'b01, "R2 R8 ticked match sets alarm 0 only");
  endtask

  task automatic t_hold_clear;
    repeat (3) @(negedge clk);
    check(flag, 2'b01, "R6 flag holds");
    set_time(8'h31, 8'h15, 8'h12, 8'h04, 8'h07, 8'h02);
    step(1'b0, 2'b10);
    check(flag, 2'b01, "R8 clear of alarm 1 leaves alarm 0");
    step(1'b0, 2'b01);
    check(flag, 2'b00, "R6 clear empties flag");
  endtask

  task automatic t_mismatch;
    step(1'b1, 2'b00);
    check(flag, 2'b00, "R11 seconds differ");
  endtask

  task automatic t_disabled_field;
    wr(1'b0, 3'd2, 8'h05);   // hour 05 stored but disabled
    set_time(8'h30, 8'h15, 8'h12, 8'h04, 8'h07, 8'h02);
    step(1'b1, 2'b00);
    check(flag, 2'b01, "R3 disabled hour ignored");
    step(1'b0, 2'b01);
  endtask

  task automatic t_yearly;
    wr(1'b1, 3'd0, 8'h80);
    wr(1'b1, 3'd1, 8'h80);
    wr(1'b1, 3'd2, 8'h89);
    wr(1'b1, 3'd3, 8'h84);
    wr(1'b1, 3'd4, 8'h87);
    set_time(8'h00, 8'h00, 8'h09, 8'h04, 8'h07, 8'h06);
    step(1'b1, 2'b00);
    check(flag, 2'b10, "R8 yearly alarm 1 only");
    step(1'b1, 2'b10);
    check(flag, 2'b10, "R7 set wins over clear");
    set_time(8'h00, 8'h00, 8'h09, 8'h04, 8'h08, 8'h06);
    step(1'b1, 2'b10);
    check(flag, 2'b00, "R11 R6 month differs and clear");
  endtask

  task automatic t_mode_bit;
    set_time(8'h80, 8'h80, 8'h89, 8'h84, 8'h87, 8'h03);
    step(1'b1, 2'b00);
    check(flag, 2'b10, "R10 bit 7 of time bytes ignored");
    step(1'b0, 2'b10);
  endtask

  task automatic t_encoding;
    wr(1'b1, 3'd6, 8'hFF);
    wr(1'b1, 3'd7, 8'hFF);
    set_time(8'h00, 8'h00, 8'h09, 8'h04, 8'h07, 8'h01);
    step(1'b1, 2'b00);
    check(flag, 2'b10, "R9 field 6/7 writes ignored");
    step(1'b0, 2'b10);
    wr(1'b1, 3'd5, 8'h83);   // weekday 3 enabled
    step(1'b1, 2'b00);
    check(flag, 2'b00, "R9 weekday field compared");
    set_time(8'h00, 8'h00, 8'h09, 8'h04, 8'h07, 8'h03);
    step(1'b1, 2'b00);
    check(flag, 2'b10, "R9 weekday matches");
    step(1'b0, 2'b10);
  endtask

  task automatic t_no_enable;
    wr(1'b0, 3'd0, 8'h30);
    wr(1'b0, 3'd1, 8'h15);
    set_time(8'h30, 8'h15, 8'h05, 8'h04, 8'h07, 8'h02);
    step(1'b1, 2'b00);
    check(flag, 2'b00, "R4 alarm 0 with no enables");
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_field = '0; wr_data = '0;
    now = '0; tick = 1'b0; clr = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_hold_clear();
    t_mismatch();
    t_disabled_field();
    t_yearly();
    t_mode_bit();
    t_encoding();
    t_no_enable();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule